// File: doc/BRIEF.md
# Trilinear Voxel Interpolation Unit

This unit resamples a 3D target volume through a dense displacement field. It walks the voxel grid in a fixed scan order. For each grid point it accepts one displacement vector with three signed fixed-point components. It moves the point by that vector, clamps the result into the volume and fetches the 2x2x2 cube of target voxels around the new position. It then produces one interpolated voxel.

The work is split across two sides of a memory port. The address side turns each displacement into a cube origin and three fractional offsets. It then issues four 64-bit reads, one for each (y, z) corner pair. Each read returns two x-neighbouring 32-bit voxels. The fractional offsets travel through a small internal queue to the weighting side. That side meets the responses whenever they arrive, forms the eight corner weights and accumulates the weighted sum. It emits one result word per grid point on an output stream, which can feed both a write-back path and a downstream consumer.

Top module: `trilin_interp`

## Requirements
- R1: After reset, `dispReady` is 1 and both `reqValid` and `outValid` are 0.
- R2: Displacements are assigned to grid points in scan order. The x index runs fastest, then y, then z, starting at (0,0,0). The scan wraps to the origin after the last point of the volume.
- R3: For each axis, the sample position is index*1024 minus the displacement component. Each component is a two's-complement value with 10 fractional bits.
- R4: Each axis position is clamped into [0, (DIM-1)*1024]. Its integer part is the cube origin and its low 10 bits are the fraction. When the integer part equals DIM-1, the origin becomes DIM-2 and the fraction becomes 1024.
- R5: Each accepted displacement produces exactly four read requests. They are issued in the order (y0,z0), (y0+1,z0), (y0,z0+1), (y0+1,z0+1), each with word address x0 + DIM_X*(y + DIM_Y*z). A request holds `reqValid` and `reqAddr` until `reqReady` is 1.
- R6: Responses return in request order. Bits [31:0] of `rspData` hold the voxel at x0 and bits [63:32] hold the voxel at x0+1.
- R7: On each axis the weight is 1024-f for the low corner and f for the high corner. Each corner weight is (wx*wy*wz + 2^19) >> 20.
- R8: The output is (sum of the eight corner weight times voxel products + 512), arithmetically shifted right by 10 and truncated to 32 bits. `outValid` pulses for one cycle, in the cycle after the fourth response of that grid point.
- R9: No new displacement is accepted while requests for the previous one are still being issued. None is accepted while FIFO_DEPTH grid points are still awaiting responses.
- R10: When a displacement is accepted in the same cycle as the fourth response of an earlier grid point completes, both take effect, and no result is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Displacement vector present |
| dispReady | output | 1 | Displacement can be taken this cycle |
| dispU1 | input | DISP_W | X displacement, signed, 10 fraction bits |
| dispU2 | input | DISP_W | Y displacement, signed, 10 fraction bits |
| dispU3 | input | DISP_W | Z displacement, signed, 10 fraction bits |
| reqValid | output | 1 | Read request present |
| reqReady | input | 1 | Memory takes the request |
| reqAddr | output | ADDR_W | Voxel index of the lower x voxel of the pair |
| rspValid | input | 1 | Read response present |
| rspData | input | 2*VOX_W | Two x-adjacent voxels, lower x in low half |
| outValid | output | 1 | Interpolated voxel present |
| outData | output | VOX_W | Interpolated voxel, signed |

## Verification
Two events can fall in the same cycle: the address side taking a new displacement, which pushes the queue, and the fourth response of an older grid point retiring it, which pops the queue. The bench sweeps the memory latency over a range of values while the request port is always ready. This makes the five-cycle accept rhythm line up with completions for some latencies, and the bench counts the cycles where both happen. It then judges that every output still arrives, in order, with the value its own model predicts. A long-latency run fills the queue, and the bench records that `dispReady` drops while no request is pending.

// File: rtl/trilin_pkg.sv
package trilin_pkg;

  localparam int REQS_PER_VOXEL = 4;

  typedef struct packed {
    logic       load;      // take displacement, push fractions, latch origin
    logic [1:0] reqSel;    // corner pair being requested: bit0 = y+1, bit1 = z+1
    logic       rspTake;   // a response word is present
    logic [1:0] rspSel;    // corner pair the response belongs to
    logic       rspFirst;  // first response of a grid point
    logic       rspLast;   // last response of a grid point
  } strobe_t;

endpackage

// File: rtl/trilin_fifo.sv
module trilin_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] level;

  assign full  = (level == CNT_W'(DEPTH));
  assign empty = (level == '0);
  assign head  = store[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) begin
        store[wrPtr] <= din;
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (pop) begin
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      if (push && !pop) level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN) push |-> !full)
    else $error("fraction queue pushed while full");
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty)
    else $error("fraction queue popped while empty");

endmodule

// File: rtl/trilin_axis.sv
module trilin_axis #(
  parameter int DIM    = 16,
  parameter int IDX_W  = 4,
  parameter int DISP_W = 16,
  parameter int FRAC   = 10
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [DISP_W-1:0] disp,
  output logic [IDX_W-1:0]  base,
  output logic [FRAC:0]     frac
);
  localparam int CW = IDX_W + FRAC + DISP_W + 2;
  localparam logic signed [CW-1:0] LIMIT = CW'(longint'(DIM - 1) << FRAC);

  logic signed [CW-1:0] sample, clamped;
  logic [IDX_W-1:0]     intPart;

  always_comb begin
    sample = $signed({{(CW-IDX_W-FRAC){1'b0}}, idx, {FRAC{1'b0}}})
           - $signed({{(CW-DISP_W){disp[DISP_W-1]}}, disp});
    if (sample < 0)          clamped = '0;
    else if (sample > LIMIT) clamped = LIMIT;
    else                     clamped = sample;
    intPart = IDX_W'(clamped >>> FRAC);
    if (intPart == IDX_W'(DIM - 1)) begin
      base = IDX_W'(DIM - 2);
      frac = {1'b1, {FRAC{1'b0}}};
    end else begin
      base = intPart;
      frac = {1'b0, clamped[FRAC-1:0]};
    end
  end

endmodule

// File: rtl/trilin_dp.sv
module trilin_dp
  import trilin_pkg::*;
#(
  parameter int DIM_X      = 16,
  parameter int DIM_Y      = 16,
  parameter int DIM_Z      = 16,
  parameter int IDX_W      = 4,
  parameter int DISP_W     = 16,
  parameter int FRAC       = 10,
  parameter int VOX_W      = 32,
  parameter int ADDR_W     = 12,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [2:0][IDX_W-1:0]       gridIdx,
  input  logic [2:0][DISP_W-1:0]      disp,
  input  logic [2*VOX_W-1:0]          rspData,
  output logic                        fifoFull,
  output logic [ADDR_W-1:0]           reqAddr,
  output logic                        outValid,
  output logic [VOX_W-1:0]            outData
);
  localparam int FW     = FRAC + 1;
  localparam int QW     = 3 * FW;
  localparam int YZ_W   = 2 * FRAC + 2;
  localparam int P_W    = 3 * FRAC + 4;
  localparam int PROD_W = VOX_W + FRAC + 2;
  localparam int ACC_W  = VOX_W + FRAC + 6;
  localparam int DIMS [3] = '{DIM_X, DIM_Y, DIM_Z};
  localparam logic [FRAC:0]  ONE  = {1'b1, {FRAC{1'b0}}};
  localparam logic [P_W-1:0] RND3 = P_W'(1) << (2 * FRAC - 1);
  localparam logic signed [ACC_W-1:0] RND1 = ACC_W'(1) <<< (FRAC - 1);

  // ---------------- address side ----------------
  logic [2:0][IDX_W-1:0] baseNew;
  logic [2:0][FRAC:0]    fracNew;
  logic [2:0][IDX_W-1:0] origin;

  for (genvar a = 0; a < 3; a++) begin : g_axis
    trilin_axis #(
      .DIM(DIMS[a]), .IDX_W(IDX_W), .DISP_W(DISP_W), .FRAC(FRAC)
    ) axis_i (
      .idx(gridIdx[a]), .disp(disp[a]), .base(baseNew[a]), .frac(fracNew[a])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) origin <= '0;
    else if (strb.load) origin <= baseNew;
  end

  always_comb begin
    logic [ADDR_W-1:0] yA, zA;
    yA = ADDR_W'(origin[1]) + ADDR_W'(strb.reqSel[0]);
    zA = ADDR_W'(origin[2]) + ADDR_W'(strb.reqSel[1]);
    reqAddr = ADDR_W'(origin[0]) + ADDR_W'(DIM_X) * (yA + ADDR_W'(DIM_Y) * zA);
  end

  // ---------------- fraction queue ----------------
  logic [QW-1:0] qHead;
  logic          qEmpty;

  trilin_fifo #(.W(QW), .DEPTH(FIFO_DEPTH)) frac_q_i (
    .clk(clk), .rstN(rstN),
    .push(strb.load), .din({fracNew[2], fracNew[1], fracNew[0]}),
    .pop(strb.rspTake && strb.rspLast),
    .head(qHead), .full(fifoFull), .empty(qEmpty)
  );

  // ---------------- weighted sum side ----------------
  logic [FRAC:0] fx, fy, fz, wy, wz, w0, w1;
  logic [YZ_W-1:0] wyz;
  logic signed [PROD_W-1:0] t0, t1;
  logic signed [ACC_W-1:0]  acc, accNext;

  function automatic logic [FRAC:0] cornerW(input logic [YZ_W-1:0] yz, input logic [FRAC:0] x);
    logic [P_W-1:0] p;
    p = P_W'(yz) * P_W'(x) + RND3;
    return FW'(p >> (2 * FRAC));
  endfunction

  always_comb begin
    fx  = qHead[FW-1:0];
    fy  = qHead[2*FW-1:FW];
    fz  = qHead[3*FW-1:2*FW];
    wy  = strb.rspSel[0] ? fy : ONE - fy;
    wz  = strb.rspSel[1] ? fz : ONE - fz;
    wyz = YZ_W'(wy) * YZ_W'(wz);
    w0  = cornerW(wyz, ONE - fx);
    w1  = cornerW(wyz, fx);
    t0  = $signed(rspData[VOX_W-1:0])       * $signed({1'b0, w0});
    t1  = $signed(rspData[2*VOX_W-1:VOX_W]) * $signed({1'b0, w1});
    accNext = (strb.rspFirst ? '0 : acc) + ACC_W'(t0) + ACC_W'(t1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strb.rspTake && strb.rspLast;
      if (strb.rspTake) acc <= accNext;
      if (strb.rspTake && strb.rspLast)
        outData <= VOX_W'((accNext + RND1) >>> FRAC);
    end
  end

  p_rsp_has_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rspTake |-> !qEmpty)
    else $error("response without pending grid point");
  p_frac_bounded_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.rspTake |-> (fx <= ONE && fy <= ONE && fz <= ONE))
    else $error("fraction above one");
  p_out_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid)
    else $error("output valid longer than one cycle");

endmodule

// File: rtl/trilin_ctrl.sv
module trilin_ctrl
  import trilin_pkg::*;
#(
  parameter int DIM_X = 16,
  parameter int DIM_Y = 16,
  parameter int DIM_Z = 16,
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dispValid,
  output logic                  dispReady,
  input  logic                  fifoFull,
  output logic                  reqValid,
  input  logic                  reqReady,
  input  logic                  rspValid,
  output strobe_t               strb,
  output logic [2:0][IDX_W-1:0] gridIdx
);
  typedef enum logic {ST_IDLE, ST_ISSUE} state_t;

  state_t     st;
  logic [1:0] reqCnt, rspCnt;
  logic       accept;

  always_comb begin
    dispReady     = (st == ST_IDLE) && !fifoFull;
    accept        = dispValid && dispReady;
    reqValid      = (st == ST_ISSUE);
    strb.load     = accept;
    strb.reqSel   = reqCnt;
    strb.rspTake  = rspValid;
    strb.rspSel   = rspCnt;
    strb.rspFirst = (rspCnt == 2'd0);
    strb.rspLast  = (rspCnt == 2'(REQS_PER_VOXEL - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      reqCnt  <= '0;
      rspCnt  <= '0;
      gridIdx <= '0;
    end else begin
      if (accept) begin
        st     <= ST_ISSUE;
        reqCnt <= '0;
        if (gridIdx[0] != IDX_W'(DIM_X - 1)) gridIdx[0] <= gridIdx[0] + 1'b1;
        else begin
          gridIdx[0] <= '0;
          if (gridIdx[1] != IDX_W'(DIM_Y - 1)) gridIdx[1] <= gridIdx[1] + 1'b1;
          else begin
            gridIdx[1] <= '0;
            gridIdx[2] <= (gridIdx[2] == IDX_W'(DIM_Z - 1)) ? '0 : gridIdx[2] + 1'b1;
          end
        end
      end else if (st == ST_ISSUE && reqReady) begin
        reqCnt <= reqCnt + 1'b1;
        if (reqCnt == 2'(REQS_PER_VOXEL - 1)) st <= ST_IDLE;
      end
      if (rspValid) rspCnt <= rspCnt + 1'b1;
    end
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(strb.reqSel))
    else $error("request dropped before acceptance");
  p_accept_starts_issue_r9: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && dispReady |=> reqValid && !dispReady)
    else $error("accept did not start request issue");

endmodule

// File: rtl/trilin_interp.sv
module trilin_interp
  import trilin_pkg::*;
#(
  parameter int DIM_X      = 16,
  parameter int DIM_Y      = 16,
  parameter int DIM_Z      = 16,
  parameter int DISP_W     = 16,
  parameter int FRAC       = 10,
  parameter int VOX_W      = 32,
  parameter int FIFO_DEPTH = 16,
  localparam int ADDR_W    = $clog2(DIM_X * DIM_Y * DIM_Z),
  localparam int MAX_DIM   = (DIM_X > DIM_Y) ? ((DIM_X > DIM_Z) ? DIM_X : DIM_Z)
                                             : ((DIM_Y > DIM_Z) ? DIM_Y : DIM_Z),
  localparam int IDX_W     = $clog2(MAX_DIM)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dispValid,
  output logic               dispReady,
  input  logic [DISP_W-1:0]  dispU1,
  input  logic [DISP_W-1:0]  dispU2,
  input  logic [DISP_W-1:0]  dispU3,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [ADDR_W-1:0]  reqAddr,
  input  logic               rspValid,
  input  logic [2*VOX_W-1:0] rspData,
  output logic               outValid,
  output logic [VOX_W-1:0]   outData
);
  strobe_t               strb;
  logic                  fifoFull;
  logic [2:0][IDX_W-1:0] gridIdx;

  trilin_ctrl #(
    .DIM_X(DIM_X), .DIM_Y(DIM_Y), .DIM_Z(DIM_Z), .IDX_W(IDX_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
    .fifoFull(fifoFull), .reqValid(reqValid), .reqReady(reqReady),
    .rspValid(rspValid), .strb(strb), .gridIdx(gridIdx)
  );

  trilin_dp #(
    .DIM_X(DIM_X), .DIM_Y(DIM_Y), .DIM_Z(DIM_Z), .IDX_W(IDX_W),
    .DISP_W(DISP_W), .FRAC(FRAC), .VOX_W(VOX_W), .ADDR_W(ADDR_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .gridIdx(gridIdx),
    .disp({dispU3, dispU2, dispU1}), .rspData(rspData),
    .fifoFull(fifoFull), .reqAddr(reqAddr),
    .outValid(outValid), .outData(outData)
  );

endmodule

// File: tb/trilin_interp_tb_top.sv
module trilin_interp_tb_top;
  localparam int CLK_NS = 10;
  localparam int DX = 4, DY = 3, DZ = 2;
  localparam int DEPTH = 4;
  localparam int AW = $clog2(DX * DY * DZ);

  logic clk = 0, rstN = 0;
  logic dispValid = 0, dispReady;
  logic [15:0] dispU1 = 0, dispU2 = 0, dispU3 = 0;
  logic reqValid, reqReady = 0;
  logic [AW-1:0] reqAddr;
  logic rspValid = 0;
  logic [63:0] rspData = 0;
  logic outValid;
  logic [31:0] outData;

  always #(CLK_NS/2) clk = ~clk;

  trilin_interp #(.DIM_X(DX), .DIM_Y(DY), .DIM_Z(DZ), .DISP_W(16), .FRAC(10),
                  .VOX_W(32), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispReady(dispReady),
    .dispU1(dispU1), .dispU2(dispU2), .dispU3(dispU3),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspData(rspData),
    .outValid(outValid), .outData(outData));

  int total = 0, bad = 0;
  int gi = 0, gj = 0, gk = 0;
  int lat = 3, readyMode = 0, cyc = 0, rspCount = 0;
  int stallSeen = 0, coinSeen = 0;
  logic rspIsLast = 0;
  string curTag = "R1";
  int expQ[$];
  int reqExpQ[$];
  int memAddrQ[$];
  int memDueQ[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int img(input int a);
    return a * 1000 - 9000 + (a % 3) * 77;
  endfunction

  // R3/R4 model of one axis
  function automatic void axisModel(input int idx, input int u, input int dim,
                                    output int b, output int f);
    longint s, lim;
    s = longint'(idx) * 1024 - longint'(u);
    lim = longint'(dim - 1) * 1024;
    if (s < 0) s = 0;
    if (s > lim) s = lim;
    if ((s >> 10) == dim - 1) begin b = dim - 2; f = 1024; end
    else begin b = int'(s >> 10); f = int'(s & 1023); end
  endfunction

  function automatic int addrOf(input int x, input int y, input int z);
    return x + DX * (y + DY * z);
  endfunction

  task automatic send(input int u1, input int u2, input int u3);
    int bx, by, bz, fx, fy, fz;
    longint sum;
    axisModel(gi, u1, DX, bx, fx);
    axisModel(gj, u2, DY, by, fy);
    axisModel(gk, u3, DZ, bz, fz);
    for (int r = 0; r < 4; r++) reqExpQ.push_back(addrOf(bx, by + (r & 1), bz + (r >> 1)));
    sum = 0;
    for (int c = 0; c < 8; c++) begin
      longint wx, wy, wz, w;
      wx = (c & 1) ? fx : 1024 - fx;
      wy = (c & 2) ? fy : 1024 - fy;
      wz = (c & 4) ? fz : 1024 - fz;
      w = (wx * wy * wz + 524288) >> 20;                 // R7
      sum += w * img(addrOf(bx + (c & 1), by + ((c >> 1) & 1), bz + (c >> 2)));
    end
    expQ.push_back(int'((sum + 512) >>> 10));            // R8
    if (gi < DX - 1) gi++;                                // R2 scan order
    else begin
      gi = 0;
      if (gj < DY - 1) gj++;
      else begin gj = 0; gk = (gk < DZ - 1) ? gk + 1 : 0; end
    end
    @(negedge clk);
    dispValid = 1; dispU1 = 16'(u1); dispU2 = 16'(u2); dispU3 = 16'(u3);
    #1;
    while (!dispReady) begin
      if (!reqValid) stallSeen++;                         // R9 queue-full stall
      @(negedge clk); #1;
    end
    @(posedge clk);
  endtask

  task automatic quiet();
    @(negedge clk); dispValid = 0;
  endtask

  task automatic drain();
    quiet();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // memory model: handshakes recorded on the negedge before the accepting edge
  always @(negedge clk) begin
    cyc++;
    reqReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (rstN && reqValid && reqReady) begin
      int e;
      e = (reqExpQ.size() != 0) ? reqExpQ.pop_front() : -1;
      check(int'(reqAddr) == e, "R5 request address", reqAddr, e);
      memAddrQ.push_back(int'(reqAddr));
      memDueQ.push_back(cyc + lat);
    end
    if (memDueQ.size() != 0 && memDueQ[0] <= cyc) begin
      int a;
      a = memAddrQ.pop_front();
      void'(memDueQ.pop_front());
      rspValid = 1;
      rspData = {img(a + 1), img(a)};                     // R6 lane order
      rspIsLast = (rspCount % 4) == 3;
      rspCount++;
    end else begin
      rspValid = 0;
      rspIsLast = 0;
    end
  end

  // R10 coincidence observer
  always @(negedge clk) begin
    #2;
    if (rstN && dispValid && dispReady && rspValid && rspIsLast) coinSeen++;
  end

  // output monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      int e;
      e = (expQ.size() != 0) ? expQ.pop_front() : 32'hDEAD;
      check(int'(outData) == e, {curTag, " R8 output"}, $signed(outData), e);
    end
  end

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    check(dispReady == 1, "R1 dispReady after reset", dispReady, 1);
    check(reqValid == 0, "R1 reqValid after reset", reqValid, 0);
    check(outValid == 0, "R1 outValid after reset", outValid, 0);

    curTag = "R2 R6";                                     // zero displacement reproduces grid voxels
    for (int n = 0; n < 6; n++) send(0, 0, 0);
    drain();

    curTag = "R3 R7";                                     // fractional shifts
    send(300, -700, 512);   send(-100, 1023, -5);  send(1536, 257, 0);
    send(-2047, -600, 700); send(1, 2, 3);         send(999, -999, -1024);
    send(-3000, 40, 1000);  send(512, 512, 512);
    drain();

    curTag = "R4";                                        // clamping on both sides
    send(20000, 20000, 20000); send(-30000, -30000, -30000);
    send(20000, -30000, 0);    send(-30000, 20000, 100);
    send(0, 0, -30000);        send(0, -2048, 0);
    drain();

    curTag = "R5";                                        // request back-pressure
    readyMode = 1;
    for (int n = 0; n < 6; n++) send(n * 173 - 400, 300 - n * 91, n * 50);
    drain();
    readyMode = 0;

    curTag = "R9";                                        // long latency fills the queue
    lat = 40;
    for (int n = 0; n < 12; n++) send(n * 37, -n * 55, n * 11);
    drain();
    check(stallSeen > 0, "R9 stall on full queue", stallSeen, 1);

    curTag = "R10";                                       // accept coincides with completion
    for (int l = 2; l < 10; l++) begin
      lat = l;
      for (int n = 0; n < 5; n++) send(n * 211 - 300, n * 63, -n * 120);
    end
    drain();
    check(coinSeen > 0, "R10 push and pop same cycle", coinSeen, 1);
    check(expQ.size() == 0, "R8 all outputs produced", expQ.size(), 0);
    check(reqExpQ.size() == 0, "R5 all requests issued", reqExpQ.size(), 0);
    finishRun();
  end

endmodule